// File: doc/BRIEF.md
# Configurable Interrupt Aggregation Controller

The block gathers a bank of external interrupt request lines into one parent interrupt. Each line first crosses a two-flop synchroniser. A per-line detector then fires on one of four trigger modes. Two configuration bits choose the mode: an edge-select bit and a polarity bit.

Detected requests land in a status register. The parent output is raised while any status bit meets a set enable bit. Software reaches everything through a plain register port with address, write data, write strobe, read strobe and read data. It changes status only through a write-one-to-set register and a write-one-to-clear register.

The block does no priority encoding and no vectoring. Software reads the status and enable words and scans the pending bits itself.

Top module: `irq_agg_ctrl`

## Requirements
- R1: After reset, status, enable and edge-select read 0, polarity reads all ones (every line high-level), and the parent output is low.
- R2: Byte offsets are 0x00 status, 0x04 enable, 0x08 set, 0x0C clear, 0x10 polarity and 0x14 edge-select. Set and clear read back 0, and so does any other offset. Read data is 0 while the read strobe is low.
- R3: A line with edge-select 0 and polarity 1 shows a status bit equal to its synchronised input, re-evaluated every clock.
- R4: A line with edge-select 0 and polarity 0 shows a status bit equal to the inverse of its synchronised input.
- R5: A line with edge-select 1 and polarity 1 sets its status bit on a 0-to-1 transition of the synchronised input. The bit stays set after the input falls.
- R6: A line with edge-select 1 and polarity 0 sets its status bit on a 1-to-0 transition of the synchronised input. The bit stays set after the input rises.
- R7: Writing 1 to a clear bit zeroes that status bit for an edge-mode line. For a level-mode line whose input is still active, the write has no lasting effect. Clear bits written 0 change nothing.
- R8: The parent output is high exactly when some bit is 1 in both status and enable. A 0 enable bit leaves the status bit readable.
- R9: Writing 1 to a set bit makes that status bit 1 after the capturing clock edge. An edge-mode line keeps it until cleared. A level-mode line with an inactive input holds it for one cycle only.
- R10: When a qualifying edge is detected in the same cycle as a clear write to that bit, the status bit ends up 1.
- R11: A change on an input line reaches the status register on the third rising clock edge after it is applied, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (8) | Register byte offset |
| bus_wdata | input | NSRC (32) | Write data, one bit per source |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | NSRC (32) | Read data, combinational from the addressed register |
| irq_src | input | NSRC (32) | Asynchronous interrupt request lines |
| irq_parent | output | 1 | Aggregated interrupt, OR of status AND enable |

## Verification
A hardware edge and a software clear can land on the same status bit in the same clock cycle. To provoke this, the bench first sets the bit with a set write. It then raises the line in edge mode and times a clear write so that the write is captured on the same edge that registers the detected transition. Counting the two synchroniser stages puts that capture on the third edge after the input change. The bit must read 1 afterwards. A second clear with no edge present must then read 0, which shows that the first result came from the edge winning and not from an ignored write.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    // Register byte offsets; software depends on these positions.
    localparam int unsigned OFF_STATUS = 'h00;
    localparam int unsigned OFF_ENABLE = 'h04;
    localparam int unsigned OFF_SET    = 'h08;
    localparam int unsigned OFF_CLEAR  = 'h0C;
    localparam int unsigned OFF_POL    = 'h10;
    localparam int unsigned OFF_EDGE   = 'h14;

    // {edge-select, polarity}
    typedef enum logic [1:0] {
        TRIG_LVL_LOW   = 2'b00,
        TRIG_LVL_HIGH  = 2'b01,
        TRIG_EDGE_FALL = 2'b10,
        TRIG_EDGE_RISE = 2'b11
    } trig_mode_e;

    // One-hot register write decode
    typedef struct packed {
        logic en;
        logic set;
        logic clr;
        logic pol;
        logic edg;
    } wsel_t;

    function automatic trig_mode_e mode_of(logic edge_b, logic pol_b);
        return trig_mode_e'({edge_b, pol_b});
    endfunction

    function automatic logic line_hit(trig_mode_e m, logic cur, logic prev);
        logic h;
        case (m)
            TRIG_LVL_LOW:   h = ~cur;
            TRIG_LVL_HIGH:  h = cur;
            TRIG_EDGE_FALL: h = prev & ~cur;
            default:        h = cur & ~prev;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)        chain[s] <= '0;
                else if (s == 0) chain[s] <= d;
                else            chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/irq_trig.sv
module irq_trig
    import irq_agg_pkg::*;
#(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] smp,
    input  logic [N-1:0] edge_cfg,
    input  logic [N-1:0] pol_cfg,
    output logic [N-1:0] hit,
    output logic [N-1:0] lvl_act
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= smp;
    end

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_line
            assign hit[i]     = line_hit(mode_of(edge_cfg[i], pol_cfg[i]), smp[i], prev_q[i]);
            assign lvl_act[i] = pol_cfg[i] ? smp[i] : ~smp[i];
        end
    endgenerate
endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_agg_pkg::*;
#(
    parameter int unsigned N      = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N-1:0]      wdata,
    input  logic              wr,
    input  logic              rd,
    input  logic [N-1:0]      hit,
    output logic [N-1:0]      rdata,
    output logic [N-1:0]      status_q,
    output logic [N-1:0]      en_q,
    output logic [N-1:0]      pol_q,
    output logic [N-1:0]      edge_q
);
    wsel_t        ws;
    logic [N-1:0] set_v, clr_v, st_nxt;

    always_comb begin
        ws = '0;
        if (wr) begin
            case (addr)
                ADDR_W'(OFF_ENABLE): ws.en  = 1'b1;
                ADDR_W'(OFF_SET):    ws.set = 1'b1;
                ADDR_W'(OFF_CLEAR):  ws.clr = 1'b1;
                ADDR_W'(OFF_POL):    ws.pol = 1'b1;
                ADDR_W'(OFF_EDGE):   ws.edg = 1'b1;
                default: ;
            endcase
        end
    end

    assign set_v = ws.set ? wdata : '0;
    assign clr_v = ws.clr ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            pol_q  <= '1;
            edge_q <= '0;
        end else begin
            if (ws.en)  en_q   <= wdata;
            if (ws.pol) pol_q  <= wdata;
            if (ws.edg) edge_q <= wdata;
        end
    end

    // Detection outranks clear; clear outranks set.
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_stat
            assign st_nxt[i] = edge_q[i]
                ? (hit[i] | ((status_q[i] | set_v[i]) & ~clr_v[i]))
                : (hit[i] | (set_v[i] & ~clr_v[i]));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= st_nxt;
    end

    always_comb begin
        rdata = '0;
        if (rd) begin
            case (addr)
                ADDR_W'(OFF_STATUS): rdata = status_q;
                ADDR_W'(OFF_ENABLE): rdata = en_q;
                ADDR_W'(OFF_POL):    rdata = pol_q;
                ADDR_W'(OFF_EDGE):   rdata = edge_q;
                default:             rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl #(
    parameter int unsigned NSRC   = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NSRC-1:0]   bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [NSRC-1:0]   bus_rdata,
    input  logic [NSRC-1:0]   irq_src,
    output logic              irq_parent
);
    localparam int unsigned SYNC_STAGES = 2;

    logic [NSRC-1:0] smp, hit, lvl_act;
    logic [NSRC-1:0] status_q, en_q, pol_q, edge_q;

    irq_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (irq_src),
        .q   (smp)
    );

    irq_trig #(.N(NSRC)) u_trig (
        .clk      (clk),
        .rst      (rst),
        .smp      (smp),
        .edge_cfg (edge_q),
        .pol_cfg  (pol_q),
        .hit      (hit),
        .lvl_act  (lvl_act)
    );

    irq_regs #(.N(NSRC), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .hit      (hit),
        .rdata    (bus_rdata),
        .status_q (status_q),
        .en_q     (en_q),
        .pol_q    (pol_q),
        .edge_q   (edge_q)
    );

    assign irq_parent = |(status_q & en_q);
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
    import irq_agg_pkg::*;
#(
    parameter int unsigned N      = 32,
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [N-1:0]      bus_wdata,
    input logic              bus_wr,
    input logic [N-1:0]      status_q,
    input logic [N-1:0]      en_q,
    input logic [N-1:0]      pol_q,
    input logic [N-1:0]      edge_q,
    input logic [N-1:0]      hit,
    input logic [N-1:0]      lvl_act,
    input logic              irq_parent
);
    logic [N-1:0] chk_set, chk_clr;
    assign chk_set = (bus_wr && bus_addr == ADDR_W'(OFF_SET))   ? bus_wdata : '0;
    assign chk_clr = (bus_wr && bus_addr == ADDR_W'(OFF_CLEAR)) ? bus_wdata : '0;

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (status_q == '0 && en_q == '0 && edge_q == '0 && pol_q == '1));

    // R3
    level_track_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((status_q ^ $past(lvl_act)) & ~$past(edge_q) & ~$past(chk_set)) == '0));

    // R5
    edge_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(status_q) & $past(edge_q) & ~$past(chk_clr) & ~status_q) == '0));

    // R7
    edge_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_clr != '0) |=> ((status_q & $past(chk_clr & edge_q & ~hit)) == '0));

    // R9
    sw_set_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_set != '0) |=> (($past(chk_set) & ~status_q) == '0));

    // R8
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |-> !irq_parent);

    // R8
    parent_source_chk: assert property (@(posedge clk) disable iff (rst)
        irq_parent |-> ((status_q & en_q) != '0));
endmodule

bind irq_agg_ctrl irq_agg_chk #(.N(NSRC), .ADDR_W(ADDR_W)) u_irq_agg_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_wr     (bus_wr),
    .status_q   (status_q),
    .en_q       (en_q),
    .pol_q      (pol_q),
    .edge_q     (edge_q),
    .hit        (hit),
    .lvl_act    (lvl_act),
    .irq_parent (irq_parent)
);

// File: tb/test_irq_agg_ctrl.sv
module test_irq_agg_ctrl;
    localparam int unsigned N = 32;
    localparam logic [7:0] A_ST = 8'h00, A_EN = 8'h04, A_SET = 8'h08,
                           A_CLR = 8'h0C, A_POL = 8'h10, A_EDG = 8'h14;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [7:0]   bus_addr = '0;
    logic [N-1:0] bus_wdata = '0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [N-1:0] bus_rdata;
    logic [N-1:0] irq_src = '0;
    logic         irq_parent;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    always #10 clk = ~clk;

    irq_agg_ctrl i_irq_agg_ctrl (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_rdata  (bus_rdata),
        .irq_src    (irq_src),
        .irq_parent (irq_parent)
    );

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after capture.
    task automatic wr(input logic [7:0] a, input logic [N-1:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [N-1:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
        #1;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] v, prev, sticky, expv, st;
        logic [N-1:0] edg_m, pol_m;

        wait_n(3);
        rst = 1'b0;
        wait_n(1);

        // R1 reset state
        rd(A_ST, v);  chk("R1 status", v, '0);
        rd(A_EN, v);  chk("R1 enable", v, '0);
        rd(A_POL, v); chk("R1 polarity", v, '1);
        rd(A_EDG, v); chk("R1 edge", v, '0);
        chk("R1 parent", {31'b0, irq_parent}, '0);

        // R2 decode: write-only and unused offsets read 0, strobe low gives 0
        wr(A_EN, 32'h1234_5678);
        rd(A_EN, v); chk("R2 enable readback", v, 32'h1234_5678);
        bus_addr = A_EN; #1 chk("R2 no strobe", bus_rdata, '0);
        rd(A_SET, v); chk("R2 set reads 0", v, '0);
        rd(A_CLR, v); chk("R2 clear reads 0", v, '0);
        for (int a = 'h18; a < 'h40; a += 4) begin
            rd(8'(a), v); chk("R2 unused offset", v, '0);
        end
        wr(A_EN, '0);

        // R11 latency and R3 level-high
        @(negedge clk);
        irq_src = 32'h0000_00A5;
        wait_n(2);
        rd(A_ST, v); chk("R11 before third edge", v, '0);
        wait_n(1);
        rd(A_ST, v); chk("R11 at third edge", v, 32'h0000_00A5);
        irq_src = 32'h5A00_0000; wait_n(4);
        rd(A_ST, v); chk("R3 level high tracks", v, 32'h5A00_0000);
        // R7 clear on active level has no lasting effect
        wr(A_CLR, '1);
        rd(A_ST, v); chk("R7 level clear ignored", v, 32'h5A00_0000);

        // R4 level-low
        wr(A_POL, '0);
        irq_src = '1; wait_n(4);
        rd(A_ST, v); chk("R4 level low idle", v, '0);
        irq_src = ~32'h0F0F_0003; wait_n(4);
        rd(A_ST, v); chk("R4 level low active", v, 32'h0F0F_0003);

        // R9 set in level mode, inactive input: one cycle only
        irq_src = '1; wait_n(4);
        wr(A_SET, 32'h0000_F000);
        rd(A_ST, v); chk("R9 level set pulse", v, 32'h0000_F000);
        wait_n(1);
        rd(A_ST, v); chk("R9 level set drops", v, '0);

        // R5 rising edge, sticky
        wr(A_POL, '1); wr(A_EDG, '1);
        irq_src = '0; wait_n(4); wr(A_CLR, '1);
        irq_src = 32'hC000_0011; wait_n(4);
        rd(A_ST, v); chk("R5 rising sets", v, 32'hC000_0011);
        irq_src = '0; wait_n(4);
        rd(A_ST, v); chk("R5 sticky after fall", v, 32'hC000_0011);
        // R7 clear in edge mode
        wr(A_CLR, 32'h4000_0001);
        rd(A_ST, v); chk("R7 edge clear", v, 32'h8000_0010);
        wr(A_CLR, '1);

        // R9 set in edge mode is held
        wr(A_SET, 32'h0000_0300); wait_n(3);
        rd(A_ST, v); chk("R9 edge set held", v, 32'h0000_0300);
        wr(A_CLR, '1);

        // R6 falling edge
        wr(A_POL, '0);
        irq_src = 32'h00FF_0000; wait_n(4); wr(A_CLR, '1);
        rd(A_ST, v); chk("R6 no edge yet", v, '0);
        irq_src = 32'h0000_0000; wait_n(4);
        rd(A_ST, v); chk("R6 falling sets", v, 32'h00FF_0000);
        irq_src = 32'h00FF_0000; wait_n(4);
        rd(A_ST, v); chk("R6 sticky after rise", v, 32'h00FF_0000);

        // R10 edge and clear in the same cycle
        wr(A_POL, '1);
        irq_src = '0; wait_n(4); wr(A_CLR, '1);
        wr(A_SET, 32'h1);
        irq_src = 32'h1;          // applied at a falling edge
        wait_n(2);                // edge registers on the third rising edge
        wr(A_CLR, 32'h1);         // captured on that same edge
        rd(A_ST, v); chk("R10 edge beats clear", v, 32'h1);
        wr(A_CLR, 32'h1);
        rd(A_ST, v); chk("R10 plain clear", v, '0);

        // Mixed-mode sweep: all four modes side by side (R3 R4 R5 R6)
        edg_m = 32'hAAAA_AAAA; pol_m = 32'hCCCC_CCCC;
        wr(A_EDG, edg_m); wr(A_POL, pol_m);
        prev = 32'h3C3C_0FF0; irq_src = prev; wait_n(4);
        wr(A_CLR, '1);
        sticky = '0;
        for (int k = 1; k <= 24; k++) begin
            v = (32'(k) * 32'h9E37_79B9) ^ (32'(k) << 5);
            irq_src = v; wait_n(4);
            sticky |= edg_m & ((pol_m & v & ~prev) | (~pol_m & ~v & prev));
            expv = sticky | (~edg_m & ~(pol_m ^ v));
            rd(A_ST, st);
            chk("R3 R4 R5 R6 mixed sweep", st, expv);
            prev = v;
        end

        // R8 enable masks only the parent output
        for (int m = 0; m < 36; m++) begin
            logic [N-1:0] msk;
            msk = (m < 32) ? (32'h1 << m) : ((m == 32) ? '0 : (m == 33) ? '1 :
                  (m == 34) ? st : ~st);
            wr(A_EN, msk);
            chk("R8 parent", {31'b0, irq_parent}, {31'b0, |(st & msk)});
            rd(A_ST, v); chk("R8 status unmasked", v, st);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule